// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block sits beside an SMBus slave and gives it a place in the alert-response procedure. It owns an open-drain alert output. A monitoring tick raises the alert whenever any bit of a status-latch input is set. When the bus master reads from the reserved alert response address, the block takes part only if its alert is pending. It acknowledges the address, then sends its own 7-bit device address as the data byte. It checks every bit it releases against the wire, so that the alerting device with the lowest address wins, as in normal open-drain arbitration.

A device that loses arbitration drops off the bus and keeps its alert raised, ready for a later alert-response read. A device that wins clears its alert once the last data bit has been clocked out. The alert comes back on a later monitoring tick if the fault is still present. SCL and SDA arrive already synchronised to `clk`, the same samples the slave interface uses. The block registers them once to find edges and START/STOP conditions.

Top module: `smb_alert_responder`

## Requirements
- R1: After reset, neither `sda_pull` nor `alert_pull` is asserted.
- R2: A `mon_tick` pulse while any bit of `status` is 1 asserts `alert_pull` in the following cycle. A tick with `status` all zero does nothing, and so does a nonzero `status` without a tick.
- R3: The block acknowledges only the address byte 0x19 (7-bit address 0001100, read bit 1), and only while `alert_pull` is asserted. It acknowledges by driving SDA low through the ninth SCL high phase. It never acknowledges any other byte, including 0x18 and its own device address, nor 0x19 while no alert is pending.
- R4: After the acknowledge, the block sends 8 bits MSB first: `dev_addr[6]` down to `dev_addr[0]`, then a 1. It changes SDA only while SCL is low.
- R5: On an SCL rising edge during the data byte, if the block is releasing SDA but sees SDA low, it stops driving for the rest of the transfer. In that case `alert_pull` stays asserted.
- R6: If all 8 data bits go out without a loss, `alert_pull` is released in the cycle after the eighth data-bit SCL rise. The master's ACK or NACK that follows has no effect on this.
- R7: Once released, the alert is raised again only by a later tick while `status` is nonzero. A tick in the same cycle as the winning clear is overridden by the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level (wired bus value) |
| dev_addr | input | 7 | This device's 7-bit slave address |
| status | input | SW (4) | Latched limit-violation flags |
| mon_tick | input | 1 | One-cycle pulse marking a monitoring cycle |
| sda_pull | output | 1 | When 1, pull SDA low |
| alert_pull | output | 1 | When 1, pull the alert line low |

## Verification
A winning transfer clears the alert, and a monitoring tick with a nonzero status sets it. Both can land in the same clock cycle. The bench provokes this by raising the eighth data-bit SCL edge and pulsing `mon_tick` on the same clock, with `status` held nonzero. It then expects the alert to be released and to stay released until a separate, later tick re-raises it.

// File: rtl/smb_alert_responder.sv
module smb_alert_responder #(
  parameter int AW = 7,
  parameter int SW = 4,
  parameter logic [AW-1:0] ARA = 7'b0001100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic [AW-1:0] dev_addr,
  input  logic [SW-1:0] status,
  input  logic          mon_tick,
  output logic          sda_pull,
  output logic          alert_pull
);
  localparam int BW = AW + 1;
  localparam int CW = $clog2(BW);
  localparam logic [BW-1:0] ARA_RD = {ARA, 1'b1};
  localparam logic [CW-1:0] LAST = CW'(BW - 1);

  typedef enum logic [2:0] {IDLE, ADDR, ACK, SEND, DONE} st_t;

  st_t           st;
  logic          scl_q, sda_q;
  logic [CW-1:0] cnt;
  logic [BW-1:0] sh;

  wire scl_rise = scl_in & ~scl_q;
  wire scl_fall = ~scl_in & scl_q;
  wire start_c  = scl_in & scl_q & sda_q & ~sda_in;
  wire stop_c   = scl_in & scl_q & ~sda_q & sda_in;
  wire [BW-1:0] rx_byte = {sh[BW-2:0], sda_in};
  wire lost = (st == SEND) & scl_rise & sh[BW-1] & ~sda_in;
  wire won  = (st == SEND) & scl_rise & ~lost & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      cnt      <= '0;
      sh       <= '0;
      sda_pull <= 1'b0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (start_c) begin
        st       <= ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_c) begin
        st       <= IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          ADDR: if (scl_rise) begin
            sh <= rx_byte;
            if (cnt == LAST) begin
              st  <= (rx_byte == ARA_RD && alert_pull) ? ACK : IDLE;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ACK: if (scl_fall) begin
            if (cnt == '0) begin
              sda_pull <= 1'b1;
              cnt      <= CW'(1);
            end else begin
              st       <= SEND;
              cnt      <= '0;
              sh       <= {dev_addr, 1'b1};
              sda_pull <= ~dev_addr[AW-1];
            end
          end
          SEND: begin
            if (lost) begin
              st       <= IDLE;
              sda_pull <= 1'b0;
            end else if (scl_rise) begin
              if (cnt == LAST) begin
                st       <= DONE;
                sda_pull <= 1'b0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end else if (scl_fall) begin
              sh       <= sh << 1;
              sda_pull <= ~sh[BW-2];
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    alert_pull <= 1'b0;
    else if (won)                  alert_pull <= 1'b0;
    else if (mon_tick && |status)  alert_pull <= 1'b1;
  end
endmodule

// File: rtl/smb_alert_responder_chk.sv
module smb_alert_responder_chk #(
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_in,
  input logic          scl_q,
  input logic          mon_tick,
  input logic [SW-1:0] status,
  input logic          sda_pull,
  input logic          alert_pull
);
  a_r2_raise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_pull) |-> $past(mon_tick && (|status)));

  a_r6_clear_on_scl_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_pull) |-> $past(scl_in && !scl_q));

  a_r3_drive_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> alert_pull);

  a_r4_hold_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    scl_in |-> $stable(sda_pull));
endmodule

bind smb_alert_responder smb_alert_responder_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .scl_q(scl_q),
  .mon_tick(mon_tick), .status(status),
  .sda_pull(sda_pull), .alert_pull(alert_pull)
);

// File: tb/smb_alert_responder_test.sv
module smb_alert_responder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, comp_pull = 1'b0;
  logic [3:0] status = '0;
  logic mon_tick = 1'b0;
  logic sda_pull, alert_pull;
  logic [6:0] my_addr = 7'b0101110;
  wire sda_w = sda_m & ~sda_pull & ~comp_pull;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  smb_alert_responder uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_w),
    .dev_addr(my_addr), .status(status), .mon_tick(mon_tick),
    .sda_pull(sda_pull), .alert_pull(alert_pull)
  );

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1; scl = 1; wt(4); sda_m = 0; wt(4); scl = 0; wt(4);
  endtask
  task automatic bus_stop;
    sda_m = 0; wt(4); scl = 1; wt(4); sda_m = 1; wt(4);
  endtask
  task automatic put_bit(input logic b);
    sda_m = b; wt(4); scl = 1; wt(4); scl = 0; wt(4);
  endtask
  task automatic get_bit(input logic cbit, input logic tick_here, output logic b);
    sda_m = 1; comp_pull = ~cbit; wt(4);
    scl = 1; mon_tick = tick_here; wt(1); mon_tick = 0; wt(2);
    b = sda_w; wt(1); scl = 0; comp_pull = 0; wt(4);
  endtask

  task automatic xfer(input logic [7:0] abyte, input logic use_comp, input logic [6:0] comp,
                      input logic tick_last, input logic m_ack,
                      output logic acked, output logic [7:0] data);
    logic b;
    logic [7:0] cb;
    cb = use_comp ? {comp, 1'b1} : 8'hFF;
    data = '0;
    bus_start();
    for (int i = 7; i >= 0; i--) put_bit(abyte[i]);
    get_bit(1'b1, 1'b0, b);
    acked = ~b;
    if (acked && abyte[0]) begin
      for (int i = 7; i >= 0; i--) begin
        get_bit(cb[i], tick_last && i == 0, b);
        data[i] = b;
      end
      put_bit(~m_ack);
    end
    bus_stop();
  endtask

  task automatic pulse_tick;
    mon_tick = 1; wt(1); mon_tick = 0;
  endtask

  task automatic t_reset;
    check(!alert_pull && !sda_pull, "R1 reset outputs", {alert_pull, sda_pull}, 0);
  endtask

  task automatic t_tick;
    status = 0; pulse_tick();
    check(!alert_pull, "R2 tick with zero status", alert_pull, 0);
    status = 4'h4; wt(5);
    check(!alert_pull, "R2 status without tick", alert_pull, 0);
    pulse_tick();
    check(alert_pull, "R2 tick with status", alert_pull, 1);
  endtask

  task automatic t_no_pending;
    logic a; logic [7:0] d;
    xfer(8'h19, 0, '0, 0, 0, a, d);
    check(!a, "R3 no ack without alert", a, 0);
    check(!sda_pull, "R3 idle drive", sda_pull, 0);
  endtask

  task automatic t_wrong_byte;
    logic a; logic [7:0] d;
    xfer(8'h18, 0, '0, 0, 0, a, d);
    check(!a, "R3 write-direction byte ignored", a, 0);
    xfer({my_addr, 1'b1}, 0, '0, 0, 0, a, d);
    check(!a, "R3 own address ignored", a, 0);
    check(alert_pull, "R3 alert untouched", alert_pull, 1);
  endtask

  task automatic t_lose;
    logic a; logic [7:0] d;
    xfer(8'h19, 1, 7'b0101100, 0, 0, a, d);
    check(a, "R3 ack when pending", a, 1);
    check(d == 8'h59, "R5 lower address on wire", d, 8'h59);
    check(alert_pull, "R5 alert kept after loss", alert_pull, 1);
    check(!sda_pull, "R5 released after loss", sda_pull, 0);
  endtask

  task automatic t_win_nack;
    logic a; logic [7:0] d;
    xfer(8'h19, 0, '0, 0, 0, a, d);
    check(a, "R3 ack on alert read", a, 1);
    check(d == 8'h5D, "R4 own address sent", d, 8'h5D);
    check(!alert_pull, "R6 cleared after nack", alert_pull, 0);
    wt(20);
    check(!alert_pull, "R7 stays clear without tick", alert_pull, 0);
    pulse_tick();
    check(alert_pull, "R7 re-raised by tick", alert_pull, 1);
  endtask

  task automatic t_win_ack;
    logic a; logic [7:0] d;
    xfer(8'h19, 1, 7'b0101111, 0, 1, a, d);
    check(d == 8'h5D, "R4 wins against higher address", d, 8'h5D);
    check(!alert_pull, "R6 cleared after master ack", alert_pull, 0);
    pulse_tick();
  endtask

  task automatic t_coincide;
    logic a; logic [7:0] d;
    check(alert_pull, "R7 pending before collision", alert_pull, 1);
    xfer(8'h19, 0, '0, 1, 0, a, d);
    check(d == 8'h5D, "R4 data in collision run", d, 8'h5D);
    check(!alert_pull, "R7 clear beats same-cycle tick", alert_pull, 0);
    pulse_tick();
    check(alert_pull, "R7 later tick re-raises", alert_pull, 1);
  endtask

  initial begin
    wt(3);
    t_reset();
    rst_n = 1; wt(3);
    t_no_pending();
    t_tick();
    t_wrong_byte();
    t_lose();
    t_win_nack();
    t_win_ack();
    t_coincide();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule